// File: doc/BRIEF.md
# Protected Fully Associative Address Translation Buffer

This block turns a virtual address from one access port into a physical address. It holds a small array of translation entries, and any virtual page may sit in any entry. Each entry is tagged with a virtual page number and a process identifier. It also carries the physical page number, an access-rights code, a user-permission bit, a present bit and a dirty bit. On every lookup all entries are compared at once. One clock later the block either returns the physical address or reports exactly one fault code: miss, page fault or protection violation. The low 13 bits are the offset within an 8 KB page and pass through unchanged. Only the page number is replaced.

On a miss the block raises `stall` for a fixed number of cycles. This stands in for the cost of fetching the entry. Requests offered during the stall are dropped. Miss-handling software fills entries through a fill port. A refill of a page that is already held overwrites that entry. Otherwise the fill takes the lowest empty slot, or a round-robin victim when the array is full. Entries can be cleared all at once or by process identifier.

The depth is a parameter. Use 8 for instruction translation and 32 for data translation.

Top module: `prot_tlb`

## Requirements
- R1: After reset `rspValid`, `rspHit` and `stall` are 0 and no entry is held, so the first lookup reports a miss.
- R2: A request accepted in cycle N is answered in cycle N+1 with `rspValid`=1. On a hit, `rspHit`=1, `rspFault`=0 and `rspPaddr` = {entry physical page number, request address bits 12..0}.
- R3: An entry matches only if it is held, its virtual page tag equals request address bits 31..13, and its process identifier equals `curPid`. An entry held for a different process gives a miss.
- R4: With no matching entry, `rspFault`=1 (miss) and `stall` is high for exactly MISS_STALL (20) cycles, starting in the response cycle. A request offered while `stall` is high is dropped and produces no response.
- R5: A matching entry whose present bit is 0 gives `rspFault`=2 (page fault), with `rspHit`=0 and no stall.
- R6: Rights codes are 0 read-only (read allowed), 1 read-write (read and write allowed), 2 execute-only (fetch allowed) and 3 no access. Access kinds are 0 read, 1 write and 2 fetch. A present match whose access is not allowed gives `rspFault`=3 (protection), with `rspHit`=0 and `rspPaddr`=0.
- R7: In kernel mode (`reqUser`=0) only the rights code applies. In user mode the access also needs the entry's user-permission bit set, otherwise `rspFault`=3.
- R8: `rspDirty` on a hit shows the entry's dirty bit as it was before that access. A permitted write sets the bit. A faulting write leaves it alone, and a fill clears it.
- R9: A fill whose page and process identifier match a held entry rewrites that entry. Otherwise it takes the lowest-numbered empty entry. When all entries are held it takes the round-robin victim, which starts at entry 0 and advances by one after each such eviction.
- R10: `invAll` clears every entry, so later lookups of those pages miss.
- R11: `invPidValid` clears only the entries whose process identifier equals `invPid`. Either clear in the same cycle as a fill drops the fill.
- R12: Every response carries exactly one outcome: `rspHit`=1 if and only if `rspFault`=0. Fault priority is miss, then page fault, then protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqVaddr | input | VA_W | Virtual address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| reqUser | input | 1 | 1 = user mode, 0 = kernel mode |
| curPid | input | PID_W | Current process identifier |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Translation succeeded |
| rspFault | output | 2 | 0 none, 1 miss, 2 page fault, 3 protection |
| rspPaddr | output | PA_W | Physical address on a hit, else 0 |
| rspDirty | output | 1 | Dirty bit of the hit entry before the access |
| stall | output | 1 | Miss penalty in progress; requests are dropped |
| fillValid | input | 1 | Write one entry |
| fillVpn | input | VA_W-13 | Virtual page number to fill |
| fillPid | input | PID_W | Process identifier of the filled entry |
| fillPpn | input | PA_W-13 | Physical page number of the filled entry |
| fillRights | input | 2 | Rights code of the filled entry |
| fillUserOk | input | 1 | User-mode permission of the filled entry |
| fillPresent | input | 1 | Present bit of the filled entry |
| invAll | input | 1 | Clear all entries |
| invPidValid | input | 1 | Clear entries of one process |
| invPid | input | PID_W | Process identifier to clear |

## Verification
Lookups are tried with a matching page and process, which shows that the offset passes through and the page number is swapped. The same page is then looked up under another process, which separates tag matching from process matching. Accesses are made to a non-present page and to each rights code under every access kind in both modes. These show the fault priority and the permission table. A run of reads, writes and faulting writes follows the dirty bit. Filling past capacity, then clearing all entries or one process's entries, checks which pages are evicted and which remain resident. The stall length is counted cycle by cycle, and a request offered during the stall must produce no response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RGT_RO   = 2'd0,
    RGT_RW   = 2'd1,
    RGT_XO   = 2'd2,
    RGT_NONE = 2'd3
  } rights_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PAGE = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lookup;
    logic fill;
    logic clrAll;
    logic clrPid;
  } strobe_t;

  function automatic logic accessOk(rights_e r, access_e a, logic userMode, logic userOk);
    if (userMode && !userOk) return 1'b0;
    case (r)
      RGT_RO:  return a == ACC_READ;
      RGT_RW:  return (a == ACC_READ) || (a == ACC_WRITE);
      RGT_XO:  return a == ACC_FETCH;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int MISS_STALL = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    fillValid,
  input  logic    invAll,
  input  logic    invPidValid,
  input  logic    noMatch,
  output strobe_t st,
  output logic    stall
);
  localparam int CNT_W = $clog2(MISS_STALL + 1);

  logic [CNT_W-1:0] stallCnt;

  assign stall = (stallCnt != '0);

  always_comb begin
    st.lookup = reqValid && !stall;
    st.clrAll = invAll;
    st.clrPid = invPidValid && !invAll;
    st.fill   = fillValid && !invAll && !invPidValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (st.lookup && noMatch) begin
      stallCnt <= CNT_W'(MISS_STALL);
    end else if (stall) begin
      stallCnt <= stallCnt - 1'b1;
    end
  end

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (st.lookup && noMatch) |=> stall); // R4

  AST_STALL_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !(st.lookup && noMatch)) |=> (stallCnt == $past(stallCnt) - 1'b1)); // R4

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int VPN_W = 19,
  parameter int PPN_W = 19,
  parameter int PID_W = 8,
  parameter int OFF_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [VPN_W-1:0]   reqVpn,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqKind,
  input  logic               reqUser,
  input  logic [PID_W-1:0]   curPid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PID_W-1:0]   fillPid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [1:0]         fillRights,
  input  logic               fillUserOk,
  input  logic               fillPresent,
  input  logic [PID_W-1:0]   invPid,
  output logic               noMatch,
  output logic               rspValid,
  output logic               rspHit,
  output logic [1:0]         rspFault,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  output logic               rspDirty
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [VPN_W-1:0] tagQ   [DEPTH];
  logic [PID_W-1:0] pidQ   [DEPTH];
  logic [PPN_W-1:0] ppnQ   [DEPTH];
  logic [1:0]       rightsQ[DEPTH];
  logic [DEPTH-1:0] userOkQ, presentQ, dirtyQ, usedQ;
  logic [IDX_W-1:0] rrQ;

  logic [DEPTH-1:0] matchVec, fillHitVec, invHitVec;
  logic [IDX_W-1:0] hitIdx, fillHitIdx, freeIdx, victimIdx;
  logic             anyFree, fillHit;
  fault_e           faultNow;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g]   = usedQ[g] && (tagQ[g] == reqVpn)  && (pidQ[g] == curPid);
    assign fillHitVec[g] = usedQ[g] && (tagQ[g] == fillVpn) && (pidQ[g] == fillPid);
    assign invHitVec[g]  = usedQ[g] && (pidQ[g] == invPid);
  end

  assign noMatch = ~|matchVec;
  assign fillHit = |fillHitVec;
  assign anyFree = ~&usedQ;

  always_comb begin
    hitIdx     = '0;
    fillHitIdx = '0;
    freeIdx    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i])   hitIdx     = IDX_W'(i);
      if (fillHitVec[i]) fillHitIdx = IDX_W'(i);
      if (!usedQ[i])     freeIdx    = IDX_W'(i);
    end
  end

  always_comb begin
    if (fillHit)      victimIdx = fillHitIdx;
    else if (anyFree) victimIdx = freeIdx;
    else              victimIdx = rrQ;
  end

  // fault priority: miss, page fault, protection
  always_comb begin
    if (noMatch)
      faultNow = FLT_MISS;
    else if (!presentQ[hitIdx])
      faultNow = FLT_PAGE;
    else if (!accessOk(rights_e'(rightsQ[hitIdx]), access_e'(reqKind), reqUser, userOkQ[hitIdx]))
      faultNow = FLT_PROT;
    else
      faultNow = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedQ    <= '0;
      dirtyQ   <= '0;
      userOkQ  <= '0;
      presentQ <= '0;
      rrQ      <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspFault <= FLT_NONE;
      rspPaddr <= '0;
      rspDirty <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        tagQ[i]    <= '0;
        pidQ[i]    <= '0;
        ppnQ[i]    <= '0;
        rightsQ[i] <= RGT_NONE;
      end
    end else begin
      rspValid <= st.lookup;
      if (st.lookup) begin
        rspFault <= faultNow;
        rspHit   <= (faultNow == FLT_NONE);
        rspPaddr <= (faultNow == FLT_NONE) ? {ppnQ[hitIdx], reqOff} : '0;
        rspDirty <= (faultNow == FLT_NONE) ? dirtyQ[hitIdx] : 1'b0;
        if ((faultNow == FLT_NONE) && (access_e'(reqKind) == ACC_WRITE))
          dirtyQ[hitIdx] <= 1'b1;
      end else begin
        rspFault <= FLT_NONE;
        rspHit   <= 1'b0;
        rspPaddr <= '0;
        rspDirty <= 1'b0;
      end

      if (st.clrAll) begin
        usedQ <= '0;
      end else if (st.clrPid) begin
        usedQ <= usedQ & ~invHitVec;
      end else if (st.fill) begin
        usedQ[victimIdx]    <= 1'b1;
        dirtyQ[victimIdx]   <= 1'b0;
        tagQ[victimIdx]     <= fillVpn;
        pidQ[victimIdx]     <= fillPid;
        ppnQ[victimIdx]     <= fillPpn;
        rightsQ[victimIdx]  <= fillRights;
        userOkQ[victimIdx]  <= fillUserOk;
        presentQ[victimIdx] <= fillPresent;
        if (!fillHit && !anyFree)
          rrQ <= (rrQ == IDX_W'(DEPTH - 1)) ? '0 : rrQ + 1'b1;
      end
    end
  end

  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R9

  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (st.lookup && !noMatch && faultNow == FLT_NONE) |=> (rspHit && rspPaddr[OFF_W-1:0] == $past(reqOff))); // R2

  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    st.fill |=> (usedQ != '0)); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    st.clrAll |=> (usedQ == '0)); // R10

  AST_DIRTY_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(st.lookup && reqKind == ACC_WRITE) && !st.fill) |=> $stable(dirtyQ)); // R8

endmodule

// File: rtl/prot_tlb.sv
module prot_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int OFF_W      = 13,
  parameter int PID_W      = 8,
  parameter int MISS_STALL = 20,
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PPN_W     = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  input  logic [PID_W-1:0] curPid,
  output logic             rspValid,
  output logic             rspHit,
  output logic [1:0]       rspFault,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspDirty,
  output logic             stall,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [1:0]       fillRights,
  input  logic             fillUserOk,
  input  logic             fillPresent,
  input  logic             invAll,
  input  logic             invPidValid,
  input  logic [PID_W-1:0] invPid
);
  strobe_t st;
  logic    noMatch;

  tlb_ctrl #(.MISS_STALL(MISS_STALL)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
    .invAll(invAll), .invPidValid(invPidValid), .noMatch(noMatch),
    .st(st), .stall(stall)
  );

  tlb_array #(
    .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W), .OFF_W(OFF_W)
  ) u_array (
    .clk(clk), .rstN(rstN), .st(st),
    .reqVpn(reqVaddr[VA_W-1:OFF_W]), .reqOff(reqVaddr[OFF_W-1:0]),
    .reqKind(reqKind), .reqUser(reqUser), .curPid(curPid),
    .fillVpn(fillVpn), .fillPid(fillPid), .fillPpn(fillPpn),
    .fillRights(fillRights), .fillUserOk(fillUserOk), .fillPresent(fillPresent),
    .invPid(invPid), .noMatch(noMatch),
    .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .rspDirty(rspDirty)
  );

endmodule

// File: tb/sim_prot_tlb.sv
`timescale 1ns/1ps
module sim_prot_tlb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [7:0]  curPid = '0;
  logic        rspValid, rspHit, rspDirty, stall;
  logic [1:0]  rspFault;
  logic [31:0] rspPaddr;
  logic        fillValid = 1'b0;
  logic [18:0] fillVpn = '0;
  logic [7:0]  fillPid = '0;
  logic [18:0] fillPpn = '0;
  logic [1:0]  fillRights = '0;
  logic        fillUserOk = 1'b0;
  logic        fillPresent = 1'b0;
  logic        invAll = 1'b0;
  logic        invPidValid = 1'b0;
  logic [7:0]  invPid = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        gValid, gHit, gDirty;
  logic [1:0]  gFault;
  logic [31:0] gPa;

  always #2 clk = ~clk;

  prot_tlb u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .reqUser(reqUser), .curPid(curPid),
    .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .rspDirty(rspDirty), .stall(stall),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPid(fillPid),
    .fillPpn(fillPpn), .fillRights(fillRights), .fillUserOk(fillUserOk),
    .fillPresent(fillPresent), .invAll(invAll), .invPidValid(invPidValid),
    .invPid(invPid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [18:0] vpn, input logic [7:0] pid, input logic [18:0] ppn,
                      input logic [1:0] rights, input logic uok, input logic pres);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = vpn; fillPid = pid; fillPpn = ppn;
    fillRights = rights; fillUserOk = uok; fillPresent = pres;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // one lookup; results in g*, waits out any stall afterwards
  task automatic look(input logic [18:0] vpn, input logic [12:0] off, input logic [7:0] pid,
                      input logic [1:0] kind, input logic user);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {vpn, off}; curPid = pid; reqKind = kind; reqUser = user;
    @(negedge clk);
    reqValid = 1'b0;
    gValid = rspValid; gHit = rspHit; gFault = rspFault; gPa = rspPaddr; gDirty = rspDirty;
    while (stall) @(negedge clk);
  endtask

  task automatic expHit(input string req, input logic [18:0] ppn, input logic [12:0] off);
    chk(gValid && gHit && gFault == 2'd0, req, {gValid, gHit, gFault}, 4'b1100);
    chk(gPa == {ppn, off}, req, gPa, {ppn, off});
  endtask

  task automatic expFault(input string req, input logic [1:0] f);
    chk(gValid && !gHit && gFault == f, req, {gValid, gHit, gFault}, {2'b10, f});
  endtask

  task automatic t_reset();
    chk(!rspValid && !rspHit && !stall, "R1", {rspValid, rspHit, stall}, 0);
    look(19'h10, 13'h0, 8'd5, 2'd0, 1'b0);
    expFault("R1", 2'd1);
  endtask

  task automatic t_hit();
    fill(19'h10, 8'd5, 19'h12345, 2'd1, 1'b1, 1'b1);
    look(19'h10, 13'h1ABC, 8'd5, 2'd0, 1'b0);
    expHit("R2", 19'h12345, 13'h1ABC);
    look(19'h10, 13'h0007, 8'd5, 2'd0, 1'b1);
    expHit("R2", 19'h12345, 13'h0007);
  endtask

  task automatic t_missStall();
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {19'h10, 13'h5}; curPid = 8'd6; reqKind = 2'd0; reqUser = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid && rspFault == 2'd1 && !rspHit, "R3", rspFault, 1);
    chk(stall, "R4", stall, 1);
    n = 1;
    reqValid = 1'b1; reqVaddr = {19'h10, 13'h5}; curPid = 8'd5;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!rspValid, "R4", rspValid, 0);
    if (stall) n++;
    while (stall) begin
      @(negedge clk);
      if (stall) n++;
    end
    chk(n == 20, "R4", n, 20);
  endtask

  task automatic t_pageFault();
    fill(19'h20, 8'd5, 19'h00AAA, 2'd1, 1'b1, 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {19'h20, 13'h0}; curPid = 8'd5; reqKind = 2'd0; reqUser = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid && !rspHit && rspFault == 2'd2 && !stall, "R5", {rspHit, rspFault, stall}, 4'b0100);
    chk(rspPaddr == 32'h0, "R12", rspPaddr, 0);
  endtask

  task automatic t_perms();
    fill(19'h30, 8'd5, 19'h00B00, 2'd0, 1'b1, 1'b1);   // read-only
    look(19'h30, 13'h10, 8'd5, 2'd1, 1'b0); expFault("R6", 2'd3);
    chk(gPa == 32'h0, "R6", gPa, 0);
    look(19'h30, 13'h10, 8'd5, 2'd2, 1'b0); expFault("R6", 2'd3);
    look(19'h30, 13'h10, 8'd5, 2'd0, 1'b1); expHit("R6", 19'h00B00, 13'h10);
    fill(19'h40, 8'd5, 19'h00C00, 2'd2, 1'b0, 1'b1);   // execute-only, kernel only
    look(19'h40, 13'h20, 8'd5, 2'd2, 1'b0); expHit("R7", 19'h00C00, 13'h20);
    look(19'h40, 13'h20, 8'd5, 2'd2, 1'b1); expFault("R7", 2'd3);
    look(19'h40, 13'h20, 8'd5, 2'd0, 1'b0); expFault("R6", 2'd3);
    fill(19'h41, 8'd5, 19'h00C01, 2'd3, 1'b1, 1'b1);   // no access
    look(19'h41, 13'h0, 8'd5, 2'd0, 1'b0); expFault("R6", 2'd3);
  endtask

  task automatic t_dirty();
    look(19'h10, 13'h0, 8'd5, 2'd0, 1'b0);
    chk(gHit && !gDirty, "R8", gDirty, 0);
    look(19'h10, 13'h0, 8'd5, 2'd1, 1'b0);
    chk(gHit && !gDirty, "R8", gDirty, 0);
    look(19'h10, 13'h0, 8'd5, 2'd0, 1'b0);
    chk(gHit && gDirty, "R8", gDirty, 1);
    look(19'h30, 13'h0, 8'd5, 2'd1, 1'b0);              // faulting write
    look(19'h30, 13'h0, 8'd5, 2'd0, 1'b0);
    chk(gHit && !gDirty, "R8", gDirty, 0);
    fill(19'h10, 8'd5, 19'h54321, 2'd1, 1'b1, 1'b1);    // refill same page
    look(19'h10, 13'h0, 8'd5, 2'd0, 1'b0);
    chk(gHit && !gDirty, "R8", gDirty, 0);
    chk(gPa == {19'h54321, 13'h0}, "R9", gPa, {19'h54321, 13'h0});
  endtask

  task automatic t_invPid();
    fill(19'h50, 8'd9, 19'h00900, 2'd0, 1'b1, 1'b1);
    @(negedge clk);
    invPidValid = 1'b1; invPid = 8'd5;
    @(negedge clk);
    invPidValid = 1'b0;
    look(19'h10, 13'h0, 8'd5, 2'd0, 1'b0); expFault("R11", 2'd1);
    look(19'h30, 13'h0, 8'd5, 2'd0, 1'b0); expFault("R11", 2'd1);
    look(19'h50, 13'h3, 8'd9, 2'd0, 1'b0); expHit("R11", 19'h00900, 13'h3);
  endtask

  task automatic t_invAll();
    @(negedge clk);
    invAll = 1'b1;
    fillValid = 1'b1; fillVpn = 19'h60; fillPid = 8'd9; fillPpn = 19'h1;
    fillRights = 2'd0; fillUserOk = 1'b1; fillPresent = 1'b1;
    @(negedge clk);
    invAll = 1'b0; fillValid = 1'b0;
    look(19'h50, 13'h0, 8'd9, 2'd0, 1'b0); expFault("R10", 2'd1);
    look(19'h60, 13'h0, 8'd9, 2'd0, 1'b0); expFault("R11", 2'd1);
  endtask

  task automatic t_victim();
    for (int i = 0; i < DEPTH; i++)
      fill(19'h100 + 19'(i), 8'd1, 19'h200 + 19'(i), 2'd1, 1'b1, 1'b1);
    look(19'h107, 13'h0, 8'd1, 2'd0, 1'b0); expHit("R9", 19'h207, 13'h0);
    fill(19'h300, 8'd1, 19'h400, 2'd1, 1'b1, 1'b1);
    look(19'h100, 13'h0, 8'd1, 2'd0, 1'b0); expFault("R9", 2'd1);
    look(19'h101, 13'h0, 8'd1, 2'd0, 1'b0); expHit("R9", 19'h201, 13'h0);
    look(19'h300, 13'h0, 8'd1, 2'd0, 1'b0); expHit("R9", 19'h400, 13'h0);
    fill(19'h301, 8'd1, 19'h401, 2'd1, 1'b1, 1'b1);
    look(19'h101, 13'h0, 8'd1, 2'd0, 1'b0); expFault("R9", 2'd1);
    look(19'h102, 13'h0, 8'd1, 2'd0, 1'b0); expHit("R9", 19'h202, 13'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_missStall();
    t_pageFault();
    t_perms();
    t_dirty();
    t_invPid();
    t_invAll();
    t_victim();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule